// File: doc/BRIEF.md
# Time-Multiplexed LUT Compute Element

This element evaluates one large Boolean function by stepping through a short program of small lookup sub-functions, one sub-function per two clock cycles, instead of building the whole function as wide combinational logic. The lookup tables live in a small memory as 2-bit entries. The memory is split into pages, and each page holds one 4-input, 2-output sub-function. A program memory of up to eight steps says which page to read, which two 2-bit operands form the rest of the address, and which temporary register takes the result. The operands can be slices of the primary input or earlier temporaries.

Software or a loader fills both memories through a single load port while the element is idle. A start pulse then latches the primary input, clears the temporaries and runs the program. When the program finishes, `done` pulses for one cycle and `result` holds all temporaries concatenated. The controller has four states. IDLE goes to ADDR on an accepted start. ADDR always goes to WB. WB goes back to ADDR for the next step, or to FIN after the final step. FIN always returns to IDLE.

Top module: `tmlut_compute`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `result` are all zero.
- R2: A start seen in IDLE latches `pi`, clears all four temporaries to zero and starts at program step 0. A start seen while `busy` is high is ignored and does not alter the running evaluation or its result.
- R3: Each step forms the LUT address as {page, operand A, operand B}. Operand source code c in 0..3 selects `pi[2c+1:2c]`, and code 4..7 selects temporary c-4.
- R4: Each step takes exactly two cycles, an address cycle (ADDR) followed by a writeback cycle (WB). In WB the 2-bit LUT entry is written into the destination temporary named by the step.
- R5: The program ends after the first step whose last bit is set, or after step 7 if no earlier step has the last bit set.
- R6: For a program of S steps, `done` is high for exactly one cycle, 2S+1 cycles after the clock edge that accepted start. At that cycle `result` equals {t3,t2,t1,t0} and holds that value until the next `done`.
- R7: Load-port writes made while `busy` is high change neither memory.
- R8: With `ld_sel`=0, a write stores `ld_data[1:0]` at LUT address `ld_addr[5:0]`. With `ld_sel`=1, a write stores `ld_data[10:0]` at program slot `ld_addr[2:0]`, using the fields last=[10], page=[9:8], A=[7:5], B=[4:2], destination=[1:0].
- R9: `busy` is high from the cycle after an accepted start through FIN, and is low in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an evaluation (accepted only when idle) |
| pi | input | 8 | Primary input, four 2-bit operand slices |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Final temporaries {t3,t2,t1,t0} |
| ld_en | input | 1 | Load-port write strobe |
| ld_sel | input | 1 | 0 selects LUT memory, 1 selects program memory |
| ld_addr | input | 6 | Write address |
| ld_data | input | 11 | Write data |

## Verification
The bench runs a four-step program, which models a 2-bit add followed by an XOR and a second add, over several primary inputs. It times each run from the edge that accepted start to `done`. If the design miscounted its pipeline registers, `done` would arrive early or late, or it would capture the result before the final writeback. A run with no last bit checks that the program stops after the eighth step. That run also shows whether temporaries are cleared: the next run would carry stale upper digits if they were not. During a run, the bench issues a second start and writes to both memories, then repeats the run. A design that accepted either would give a changed result or a changed latency.

// File: rtl/tmlut_pkg.sv
package tmlut_pkg;
    localparam int DW      = 2;
    localparam int NPI     = 4;
    localparam int NT      = 4;
    localparam int NPAGE   = 4;
    localparam int NSTEP   = 8;
    localparam int SRC_N   = NPI + NT;
    localparam int SELW    = $clog2(SRC_N);
    localparam int PGW     = $clog2(NPAGE);
    localparam int TW      = $clog2(NT);
    localparam int SIW     = $clog2(NSTEP);
    localparam int AW      = PGW + 2 * DW;
    localparam int DEPTH   = 1 << AW;
    localparam int PI_W    = NPI * DW;
    localparam int RES_W   = NT * DW;

    typedef struct packed {
        logic            last;
        logic [PGW-1:0]  page;
        logic [SELW-1:0] sel_a;
        logic [SELW-1:0] sel_b;
        logic [TW-1:0]   dst;
    } step_t;

    localparam int STEP_W  = $bits(step_t);
    localparam int LD_DW   = (STEP_W > DW) ? STEP_W : DW;
    localparam int LD_AW   = (AW > SIW) ? AW : SIW;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WB   = 2'd2,
        ST_FIN  = 2'd3
    } ctrl_state_t;
endpackage

// File: rtl/tmlut_prog_mem.sv
module tmlut_prog_mem
    import tmlut_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           busy_i,
    input  logic           we_i,
    input  logic [SIW-1:0] waddr_i,
    input  step_t          wdata_i,
    input  logic [SIW-1:0] raddr_i,
    output step_t          rdata_o
);
    step_t [NSTEP-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    AST_PROG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(mem_q)); // R7
endmodule

// File: rtl/tmlut_lut_mem.sv
module tmlut_lut_mem
    import tmlut_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DEPTH-1:0][DW-1:0] mem_q;
    logic [DW-1:0]            rd_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (re_i) begin
            rd_q <= mem_q[raddr_i];
        end
    end

    assign rdata_o = rd_q;

    AST_LUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(mem_q)); // R7
endmodule

// File: rtl/tmlut_addr_gen.sv
module tmlut_addr_gen
    import tmlut_pkg::*;
(
    input  logic [PI_W-1:0]        pi_i,
    input  logic [NT-1:0][DW-1:0]  tmp_i,
    input  step_t                  step_i,
    output logic [AW-1:0]          addr_o
);
    logic [SRC_N-1:0][DW-1:0] src;

    for (genvar g = 0; g < NPI; g++) begin : g_pi_src
        assign src[g] = pi_i[g*DW +: DW];
    end
    for (genvar g = 0; g < NT; g++) begin : g_tmp_src
        assign src[NPI+g] = tmp_i[g];
    end

    logic unused_last;
    logic [TW-1:0] unused_dst;
    assign unused_last = step_i.last;
    assign unused_dst  = step_i.dst;

    assign addr_o = {step_i.page, src[step_i.sel_a], src[step_i.sel_b]};
endmodule

// File: rtl/tmlut_ctrl.sv
module tmlut_ctrl
    import tmlut_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           step_last_i,
    input  logic [TW-1:0]  step_dst_i,
    output logic [SIW-1:0] step_idx_o,
    output logic [TW-1:0]  dst_o,
    output logic           accept_o,
    output logic           rd_o,
    output logic           wb_o,
    output logic           fin_o,
    output logic           busy_o
);
    ctrl_state_t    state_q, state_d;
    logic [SIW-1:0] idx_q;
    logic           last_q;
    logic [TW-1:0]  dst_q;
    logic           final_step;

    assign final_step = last_q || (idx_q == SIW'(NSTEP - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_WB;
            ST_WB:   state_d = final_step ? ST_FIN : ST_ADDR;
            ST_FIN:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            last_q <= 1'b0;
            dst_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                idx_q <= '0;
            end else if (state_q == ST_WB && !final_step) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_ADDR) begin
                last_q <= step_last_i;
                dst_q  <= step_dst_i;
            end
        end
    end

    always_comb begin
        accept_o   = (state_q == ST_IDLE) && start_i;
        rd_o       = (state_q == ST_ADDR);
        wb_o       = (state_q == ST_WB);
        fin_o      = (state_q == ST_FIN);
        busy_o     = (state_q != ST_IDLE);
        step_idx_o = idx_q;
        dst_o      = dst_q;
    end

    AST_ADDR_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |=> (state_q == ST_WB)); // R4
    AST_START_ENTERS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_ADDR && idx_q == '0)); // R2
    AST_STEP_LIMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WB && idx_q == SIW'(NSTEP - 1)) |=> (state_q == ST_FIN)); // R5
endmodule

// File: rtl/tmlut_compute.sv
module tmlut_compute
    import tmlut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PI_W-1:0]   pi,
    output logic              busy,
    output logic              done,
    output logic [RES_W-1:0]  result,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [LD_AW-1:0]  ld_addr,
    input  logic [LD_DW-1:0]  ld_data
);
    logic [PI_W-1:0]       pi_q;
    logic [NT-1:0][DW-1:0] tmp_q;
    logic [RES_W-1:0]      result_q;
    logic                  done_q;

    logic [SIW-1:0] step_idx;
    logic [TW-1:0]  wb_dst;
    logic           accept, rd, wb, fin, busy_w;
    step_t          cur_step;
    logic [AW-1:0]  lut_addr;
    logic [DW-1:0]  lut_data;
    logic           lut_we, prog_we;

    assign lut_we  = ld_en && !ld_sel && !busy_w;
    assign prog_we = ld_en &&  ld_sel && !busy_w;

    tmlut_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .step_last_i (cur_step.last),
        .step_dst_i  (cur_step.dst),
        .step_idx_o  (step_idx),
        .dst_o       (wb_dst),
        .accept_o    (accept),
        .rd_o        (rd),
        .wb_o        (wb),
        .fin_o       (fin),
        .busy_o      (busy_w)
    );

    tmlut_prog_mem u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy_w),
        .we_i    (prog_we),
        .waddr_i (ld_addr[SIW-1:0]),
        .wdata_i (step_t'(ld_data[STEP_W-1:0])),
        .raddr_i (step_idx),
        .rdata_o (cur_step)
    );

    tmlut_addr_gen u_agen (
        .pi_i   (pi_q),
        .tmp_i  (tmp_q),
        .step_i (cur_step),
        .addr_o (lut_addr)
    );

    tmlut_lut_mem u_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy_w),
        .we_i    (lut_we),
        .waddr_i (ld_addr[AW-1:0]),
        .wdata_i (ld_data[DW-1:0]),
        .re_i    (rd),
        .raddr_i (lut_addr),
        .rdata_o (lut_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pi_q  <= '0;
            tmp_q <= '0;
        end else if (accept) begin
            pi_q  <= pi;
            tmp_q <= '0;
        end else if (wb) begin
            tmp_q[wb_dst] <= lut_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= fin;
            if (fin) begin
                result_q <= tmp_q;
            end
        end
    end

    assign busy   = busy_w;
    assign done   = done_q;
    assign result = result_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R6
    AST_TEMPS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tmp_q == '0 && busy)); // R2
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
endmodule

// File: tb/tmlut_compute_tb.sv
`timescale 1ns/1ps
module tmlut_compute_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  pi = '0;
    logic        busy, done;
    logic [7:0]  result;
    logic        ld_en = 1'b0;
    logic        ld_sel = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [10:0] ld_data = '0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    tmlut_compute u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pi(pi),
        .busy(busy), .done(done), .result(result),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    localparam int NVEC = 6;
    localparam logic [7:0] VEC_PI [NVEC] = '{8'h00, 8'h1B, 8'h3F, 8'h25, 8'hE7, 8'h0A};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] mk(input bit last, input int page, input int sa, input int sb, input int dst);
        return {last, 2'(page), 3'(sa), 3'(sb), 2'(dst)};
    endfunction

    // Model of the four-step program (R3 operand coding, R4 writeback)
    function automatic logic [7:0] model(input logic [7:0] p);
        logic [1:0] p0, p1, p2, t0, t1, t2, t3;
        logic [2:0] s;
        p0 = p[1:0]; p1 = p[3:2]; p2 = p[5:4];
        s  = p0 + p1;
        t0 = s[1:0];
        t1 = {1'b0, s[2]};
        t2 = t0 ^ p2;
        t3 = 2'(t2 + t1);
        return {t3, t2, t1, t0};
    endfunction

    task automatic ld(input bit sel, input int addr, input logic [10:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = 6'(addr); ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Runs one evaluation; inj adds a start and two writes while busy (R2, R7)
    task automatic run(input logic [7:0] p, input int nsteps, input logic [7:0] exp_res, input bit inj, input string tag);
        int cyc;
        @(negedge clk);
        pi = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 60) begin
            if (cyc == 2) chk(busy == 1'b1, "R9 busy during run", 32'(busy), 1);
            if (inj && cyc == 3) begin start = 1'b1; pi = ~p; end
            else start = 1'b0;
            if (inj && cyc == 4) begin ld_en = 1'b1; ld_sel = 1'b0; ld_addr = 6'd5; ld_data = 11'h3 ^ 11'(ld_data); end
            else if (inj && cyc == 5) begin ld_en = 1'b1; ld_sel = 1'b1; ld_addr = 6'd0; ld_data = mk(1, 3, 7, 7, 3); end
            else ld_en = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; ld_en = 1'b0;
        chk(done == 1'b1, {"R6 done seen ", tag}, 32'(done), 1);
        chk(cyc - 1 == 2 * nsteps + 1, {"R6 latency ", tag}, 32'(cyc - 1), 32'(2 * nsteps + 1));
        chk(result == exp_res, {"R6 result ", tag}, 32'(result), 32'(exp_res));
        chk(busy == 1'b0, {"R9 idle at done ", tag}, 32'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0 && result == exp_res, {"R6 single pulse and hold ", tag}, {done, result}, {1'b0, exp_res});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R6 watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && result == 0, "R1 reset state", {busy, done, result}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && result == 0, "R1 after reset", {busy, done, result}, 0);

        // R8: LUT pages: 0 add, 1 xor, 2 carry, 3 increment of A; index {page,a,b}
        for (int pg = 0; pg < 4; pg++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    logic [1:0] v;
                    case (pg)
                        0: v = 2'(a + b);
                        1: v = 2'(a ^ b);
                        2: v = 2'((a + b) >> 2);
                        default: v = 2'(a + 1);
                    endcase
                    ld(1'b0, pg * 16 + a * 4 + b, 11'(v));
                end
            end
        end
        // R8 program slots: four steps, last bit on step 3
        ld(1'b1, 0, mk(0, 0, 0, 1, 0));
        ld(1'b1, 1, mk(0, 2, 0, 1, 1));
        ld(1'b1, 2, mk(0, 1, 4, 2, 2));
        ld(1'b1, 3, mk(1, 0, 6, 5, 3));

        // R3 R4: table of vectors walked by one loop
        for (int i = 0; i < NVEC; i++) begin
            run(VEC_PI[i], 4, model(VEC_PI[i]), 1'b0, $sformatf("vec%0d", i));
        end

        // R2 R7: start and writes while busy are ignored
        run(8'h1B, 4, model(8'h1B), 1'b1, "busy-inject");
        run(8'h1B, 4, model(8'h1B), 1'b0, "after-inject");

        // R5: eight steps, no last bit; t0 incremented 7 times, then t1 = t0+t0
        for (int s = 0; s < 7; s++) ld(1'b1, s, mk(0, 3, 4, 4, 0));
        ld(1'b1, 7, mk(0, 0, 4, 4, 1));
        run(8'hFF, 8, 8'h0B, 1'b0, "R5 eight-step");

        // R2: temporaries cleared; a single-step program leaves t1..t3 zero
        ld(1'b1, 0, mk(1, 1, 0, 3, 0));
        run(8'hC6, 1, 8'h01, 1'b0, "R2 one-step clear");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule